// File: doc/BRIEF.md
# Word Substituter with Gated Debug Capture

This block passes a 32-bit word through the forward byte substitution of the AES cipher. Each of the four bytes has its own lookup, and each result is held in a register. The substituted word appears one clock after the input is sampled. No key expansion and no round logic is included. The block is meant to sit in front of a datapath that needs the nonlinear byte layer on its own.

A debug port beside the datapath shows the raw input word as it was sampled at the last clock edge, but only while the debug enable is held high. The enable also gates the port output directly, with no register in between. Whenever the enable is low the port reads zero, so no internal value can reach it in normal operation.

A detector compares the next substituted word with a rare-trigger pattern set by a parameter. It raises a sticky alert in the cycle that pattern first appears on the output. The alert stays high until reset.

Top module: `word_sub_top`

## Requirements
- R1: The input word is split into four bytes, bits 31:24, 23:16, 15:8 and 7:0. Each byte is substituted independently, and its result occupies the same bit range of `sub_out`.
- R2: `sub_out` is registered. After a rising edge where reset is low, it equals the substitution of the `din` value sampled at that edge, and it holds until the next edge.
- R3: The substitution is the AES forward S-box, the multiplicative inverse in GF(2^8) modulo x^8+x^4+x^3+x+1 (with 0 mapped to 0) followed by the affine map with constant 0x63. Sample values: 0x00 to 0x63, 0x01 to 0x7c, 0x53 to 0xed, 0xff to 0x16.
- R4: While `dbg_en` is high at a rising edge and is still high afterwards, `dbg_out` equals the `din` value sampled at that edge.
- R5: Whenever `dbg_en` is low, `dbg_out` is zero in that same cycle, even between clock edges. An edge sampled with `dbg_en` low also clears the capture register.
- R6: `alert` goes high in the first cycle in which `sub_out` equals the parameter TRIGGER (default 0x7c7c7c7c, produced when every input byte is 0x01).
- R7: Once set, `alert` stays high whatever the later inputs are, until a reset.
- R8: Synchronous active-high reset `rst` clears `sub_out`, the debug capture and `alert` at the rising edge.
- R9: An output that differs from TRIGGER in any bit does not set `alert`. For example, input 0x01010100 gives 0x7c7c7c63 and leaves `alert` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| dbg_en | input | 1 | Debug access enable |
| din | input | 32 | Input word |
| sub_out | output | 32 | Registered substituted word |
| dbg_out | output | 32 | Debug view of the captured input, zero when disabled |
| alert | output | 1 | Sticky rare-pattern alert |

## Verification
The bench computes the S-box its own way, by brute-force inverse search and rotation-based affine mixing. It then checks every lane against random words and the known sample bytes. A design that swapped lanes or used a wrong table entry would show mismatched bytes in `sub_out`. The bench drops `dbg_en` between clock edges to catch a design that only clears the debug register at the next edge, because such a design would leak the captured word for part of a cycle. It also applies the near-miss word 0x01010100 followed by the exact trigger, and then keeps applying other words. This exposes three faults: an alert that fires on a partial match, one that lags a cycle behind the output, and one that is not sticky.

// File: rtl/word_sub_pkg.sv
package word_sub_pkg;

  localparam int BYTE_W = 8;

  function automatic logic [7:0] gf_mul(input logic [7:0] a, input logic [7:0] b);
    logic [7:0] acc;
    logic [7:0] sh;
    acc = 8'h00;
    sh  = a;
    for (int i = 0; i < 8; i++) begin
      if (b[i]) acc = acc ^ sh;
      sh = {sh[6:0], 1'b0} ^ (sh[7] ? 8'h1b : 8'h00);
    end
    return acc;
  endfunction

  // x^254 equals the inverse for nonzero x and 0 for x = 0
  function automatic logic [7:0] gf_inv(input logic [7:0] x);
    logic [7:0] sq;
    logic [7:0] r;
    sq = x;
    r  = 8'h01;
    for (int i = 1; i < 8; i++) begin
      sq = gf_mul(sq, sq);
      r  = gf_mul(r, sq);
    end
    return r;
  endfunction

  function automatic logic [7:0] affine(input logic [7:0] b);
    logic [7:0] o;
    logic [7:0] c;
    c = 8'h63;
    for (int i = 0; i < 8; i++) begin
      o[i] = b[i] ^ b[(i + 4) % 8] ^ b[(i + 5) % 8] ^ b[(i + 6) % 8] ^ b[(i + 7) % 8] ^ c[i];
    end
    return o;
  endfunction

  function automatic logic [7:0] sbox(input logic [7:0] x);
    return affine(gf_inv(x));
  endfunction

  function automatic logic [31:0] sbox_word(input logic [31:0] w);
    logic [31:0] o;
    for (int k = 0; k < 4; k++) begin
      o[k*8 +: 8] = sbox(w[k*8 +: 8]);
    end
    return o;
  endfunction

endpackage

// File: rtl/sbox_lane.sv
module sbox_lane
  import word_sub_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic [7:0] byte_in,
  output logic [7:0] byte_next,
  output logic [7:0] byte_q
);
  assign byte_next = sbox(byte_in);

  always_ff @(posedge clk) begin
    if (rst) byte_q <= '0;
    else     byte_q <= byte_next;
  end
endmodule

// File: rtl/debug_gate.sv
module debug_gate #(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic [WIDTH-1:0] data_in,
  output logic [WIDTH-1:0] view
);
  logic [WIDTH-1:0] cap_q;

  always_ff @(posedge clk) begin
    if (rst)     cap_q <= '0;
    else if (en) cap_q <= data_in;
    else         cap_q <= '0;
  end

  // combinational gate: the port is zero in any cycle with the enable low
  assign view = cap_q & {WIDTH{en}};
endmodule

// File: rtl/rare_alert.sv
module rare_alert #(
  parameter int          WIDTH   = 32,
  parameter logic [31:0] TRIGGER = 32'h7c7c7c7c
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] next_word,
  output logic             hit,
  output logic             flag
);
  assign hit = (next_word == TRIGGER[WIDTH-1:0]);

  always_ff @(posedge clk) begin
    if (rst)      flag <= 1'b0;
    else if (hit) flag <= 1'b1;
  end
endmodule

// File: rtl/word_sub_top.sv
module word_sub_top #(
  parameter int          WIDTH   = 32,
  parameter logic [31:0] TRIGGER = 32'h7c7c7c7c
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             dbg_en,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] sub_out,
  output logic [WIDTH-1:0] dbg_out,
  output logic             alert
);
  localparam int LANES = WIDTH / 8;

  logic [WIDTH-1:0] sub_next;
  logic             trig_hit;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    sbox_lane u_lane (
      .clk      (clk),
      .rst      (rst),
      .byte_in  (din[g*8 +: 8]),
      .byte_next(sub_next[g*8 +: 8]),
      .byte_q   (sub_out[g*8 +: 8])
    );
  end

  debug_gate #(.WIDTH(WIDTH)) u_dbg (
    .clk    (clk),
    .rst    (rst),
    .en     (dbg_en),
    .data_in(din),
    .view   (dbg_out)
  );

  rare_alert #(.WIDTH(WIDTH), .TRIGGER(TRIGGER)) u_alert (
    .clk      (clk),
    .rst      (rst),
    .next_word(sub_next),
    .hit      (trig_hit),
    .flag     (alert)
  );
endmodule

// File: rtl/word_sub_checker.sv
module word_sub_checker
  import word_sub_pkg::*;
#(
  parameter int          WIDTH   = 32,
  parameter logic [31:0] TRIGGER = 32'h7c7c7c7c
) (
  input logic             clk,
  input logic             rst,
  input logic             dbg_en,
  input logic [WIDTH-1:0] din,
  input logic [WIDTH-1:0] sub_out,
  input logic [WIDTH-1:0] dbg_out,
  input logic             alert,
  input logic             trig_hit
);
  logic started;
  always_ff @(posedge clk) started <= 1'b1;

  assert_sub_latency_R2: assert property (@(posedge clk) disable iff (rst)
    (started && !$past(rst)) |-> (sub_out == sbox_word($past(din))));

  assert_dbg_capture_R4: assert property (@(posedge clk) disable iff (rst)
    (started && !$past(rst) && $past(dbg_en) && dbg_en) |-> (dbg_out == $past(din)));

  assert_dbg_zero_R5: assert property (@(posedge clk) disable iff (rst)
    !dbg_en |-> (dbg_out == '0));

  assert_alert_on_pattern_R6: assert property (@(posedge clk) disable iff (rst)
    (sub_out == TRIGGER[WIDTH-1:0] && started && !$past(rst)) |-> alert);

  assert_alert_sticky_R7: assert property (@(posedge clk) disable iff (rst)
    alert |=> alert);

  assert_alert_cause_R9: assert property (@(posedge clk) disable iff (rst)
    (started && $rose(alert)) |-> ($past(trig_hit) && sub_out == TRIGGER[WIDTH-1:0]));
endmodule

bind word_sub_top word_sub_checker #(.WIDTH(WIDTH), .TRIGGER(TRIGGER)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .dbg_en  (dbg_en),
  .din     (din),
  .sub_out (sub_out),
  .dbg_out (dbg_out),
  .alert   (alert),
  .trig_hit(trig_hit)
);

// File: tb/word_sub_top_test.sv
`timescale 1ns/1ps
module word_sub_top_test;
  localparam logic [31:0] TRIG = 32'h7c7c7c7c;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        dbg_en = 1'b0;
  logic [31:0] din = '0;
  logic [31:0] sub_out, dbg_out;
  logic        alert;

  int tests = 0;
  int fails = 0;
  logic [7:0] tbl [256];
  logic [31:0] e_sub, e_cap;
  logic        e_alert;

  always #10 clk = ~clk;

  word_sub_top uut (
    .clk(clk), .rst(rst), .dbg_en(dbg_en), .din(din),
    .sub_out(sub_out), .dbg_out(dbg_out), .alert(alert)
  );

  function automatic logic [7:0] mulx(input logic [7:0] a, input logic [7:0] b);
    logic [7:0] r = 0;
    logic [7:0] aa = a;
    logic [7:0] bb = b;
    while (bb != 0) begin
      if (bb[0]) r ^= aa;
      aa = aa[7] ? ((aa << 1) ^ 8'h1b) : (aa << 1);
      bb = bb >> 1;
    end
    return r;
  endfunction

  function automatic logic [7:0] rotl(input logic [7:0] v, input int n);
    return (v << n) | (v >> (8 - n));
  endfunction

  function automatic logic [7:0] ref_sbox(input int x);
    logic [7:0] inv = 0;
    for (int j = 1; j < 256; j++)
      if (mulx(8'(x), 8'(j)) == 8'h01) inv = 8'(j);
    return inv ^ rotl(inv, 1) ^ rotl(inv, 2) ^ rotl(inv, 3) ^ rotl(inv, 4) ^ 8'h63;
  endfunction

  function automatic logic [31:0] ref_word(input logic [31:0] w);
    return {tbl[w[31:24]], tbl[w[23:16]], tbl[w[15:8]], tbl[w[7:0]]};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // drive inputs, clock once, update model, check all outputs
  task automatic step(input logic r, input logic en, input logic [31:0] d, input string req);
    rst = r; dbg_en = en; din = d;
    @(posedge clk);
    if (r) begin
      e_sub = 0; e_cap = 0; e_alert = 0;
    end else begin
      e_sub = ref_word(d);
      e_cap = en ? d : 32'h0;
      if (e_sub == TRIG) e_alert = 1'b1;
    end
    #2;
    check({req, " sub_out"}, sub_out, e_sub);
    check({req, " dbg_out"}, dbg_out, en ? e_cap : 32'h0);
    check({req, " alert"}, {31'h0, alert}, {31'h0, e_alert});
  endtask

  initial begin
    #4_000_000;
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    for (int i = 0; i < 256; i++) tbl[i] = ref_sbox(i);
    check("R3 s(00)", {24'h0, tbl[8'h00]}, 32'h63);
    check("R3 s(01)", {24'h0, tbl[8'h01]}, 32'h7c);
    check("R3 s(53)", {24'h0, tbl[8'h53]}, 32'hed);
    check("R3 s(ff)", {24'h0, tbl[8'hff]}, 32'h16);

    // R8 reset state, with debug enabled and data present
    step(1, 1, 32'hdeadbeef, "R8 reset");
    step(1, 1, 32'h01010101, "R8 reset hold");

    // R1 R3 lane placement with distinct bytes
    step(0, 1, 32'h00015300, "R1 lanes");
    step(0, 1, 32'hff000153, "R1 lanes rot");
    // R2 hold: one extra cycle with the same input
    step(0, 1, 32'hff000153, "R2 hold");

    // R5: drop enable between edges, port must clear immediately
    #3 dbg_en = 1'b0; #1;
    check("R5 mid-cycle zero", dbg_out, 32'h0);
    dbg_en = 1'b1; #1;
    check("R4 reenable view", dbg_out, 32'hff000153);
    step(0, 0, 32'h12345678, "R5 disabled edge");
    // after a disabled edge the capture was cleared
    step(0, 1, 32'h0badf00d, "R4 capture");

    // R9 near miss, then R6 trigger, then R7 sticky
    step(0, 1, 32'h01010100, "R9 near miss");
    step(0, 0, 32'h00010101, "R9 near miss2");
    step(0, 1, 32'h01010101, "R6 trigger");
    step(0, 1, 32'h01010101, "R6 trigger again");

    for (int i = 0; i < 300; i++)
      step(0, 1'($urandom_range(0, 1)), $urandom(), "R7 R2 R4 random");

    // R8 reset clears sticky alert
    step(1, 0, 32'h01010101, "R8 reset clears");
    for (int i = 0; i < 300; i++)
      step(0, 1'($urandom_range(0, 1)), $urandom(), "R1 R5 random");

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule